// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is a clock-synchronous model of the command front end of a 16-bit-wide NOR flash. The host drives chip enable, write enable and output enable (all active low), a 20-bit word address and a 16-bit data bus. The block picks out bus writes and matches them against unlock-guarded command sequences. These sequences start a word program, an erase of a 2K-word sector, an erase of a 32K-word block or of the whole array. Other sequences switch the read path into an identification view or a query view, or switch it back to plain array reads.

Program and erase start a busy phase of fixed length, set by parameters in clock cycles. While the block is busy, reads return a status word instead of memory contents, and every write is dropped. The storage behind the interface is a sparse behavioural array of 16 words, spread over two sectors in each of two blocks. This makes the sector and block selection visible at the ports.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset busy_o is 0, the read view is the plain array, every mapped word reads FFFFh, and data_o is 0000h.
- R2: data_o shows read data only while ce_ni=0, oe_ni=0 and we_ni=1, and is 0000h otherwise. The mapped words are at the addresses whose bits other than 16, 11, 1 and 0 are all zero. Any other address reads FFFFh.
- R3: The bus writes AAh@05555h, 55h@02AAAh, A0h@05555h, followed by a write of D to address A, program A so that it holds its old value AND D. Data bits 15:8 of the three command cycles are ignored.
- R4: The bus writes AAh@05555h, 55h@02AAAh, 80h@05555h, AAh@05555h, 55h@02AAAh, followed by 30h at address A, set to FFFFh every word whose address bits 19:11 equal those of A. No other word changes.
- R5: The same five-cycle prefix followed by 50h at address A sets to FFFFh every word whose address bits 19:15 equal those of A.
- R6: The same five-cycle prefix followed by 10h@05555h sets every word to FFFFh.
- R7: busy_o rises in the cycle after the final write and stays high for PROG_CYC cycles after a program or ERASE_CYC cycles after an erase. The array change is visible once busy_o has fallen.
- R8: A read while busy returns a status word with every bit 0 except bits 7 and 6. Bit 7 is the inverse of bit 7 of the data being programmed, or 0 during an erase. Once the operation is done, reads return array data again.
- R9: Bit 6 of the status word is 1 on the first read of a busy phase and inverts on each further read.
- R10: Every write made while busy_o is 1 is ignored, including the exit sequence.
- R11: AAh@05555h, 55h@02AAAh, 90h@05555h select the identification view. In that view address 0 reads MFR_ID (default 00BFh), address 1 reads DEV_ID (default 2782h), and any other address reads 0000h. The view lasts until AAh@05555h, 55h@02AAAh, F0h@05555h.
- R12: AAh@05555h, 55h@02AAAh, 98h@05555h select the query view. In that view addresses 10h, 11h and 12h read 0051h, 0052h and 0059h, and any other address reads 0000h. Only the exit sequence leaves this view.
- R13: A write that does not fit the sequence in progress is discarded, and matching starts again from the first cycle. If the identification view is active, such a write also returns the block to array reads.
- R14: A write or read is counted once per falling edge of the combined strobe, however many cycles the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 20 | Word address |
| data_i | input | 16 | Write data |
| data_o | output | 16 | Read data or status word |
| busy_o | output | 1 | Program or erase in progress |

## Verification
The checker assumes the host never asserts write enable and output enable together, and that it releases a strobe for at least one cycle between accesses. Under these conditions every busy phase begins right after a write edge, and every toggle read is a separate edge. The bench drives all bus signals on the falling clock edge. Each access is exactly one cycle long and is followed by a one-cycle release. The only exception is the held-strobe case, which keeps enable low for several cycles on purpose. Expected array contents come from a shadow model in the bench that applies the address-bit rules of the requirements to all 16 mapped words.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam int AW = 20;
  localparam int DW = 16;

  localparam logic [AW-1:0] UNLOCK_A1 = 20'h05555;
  localparam logic [AW-1:0] UNLOCK_A2 = 20'h02AAA;

  localparam logic [7:0] CMD_UL1   = 8'hAA;
  localparam logic [7:0] CMD_UL2   = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_ID    = 8'h90;
  localparam logic [7:0] CMD_QRY   = 8'h98;
  localparam logic [7:0] CMD_EXIT  = 8'hF0;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_BLK   = 8'h50;
  localparam logic [7:0] CMD_CHIP  = 8'h10;

  typedef enum logic [1:0] {VIEW_ARRAY, VIEW_ID, VIEW_QRY} view_e;
  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_BLK, OP_CHIP} op_e;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E3, SQ_E4, SQ_E5
  } seq_e;
endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_seq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          busy_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    cmd_i,
  output logic          start_o,
  output op_e           op_o,
  output view_e         view_o
);
  seq_e  seq_q, seq_d;
  view_e view_q, view_d;
  logic  bad;
  logic  at_a1, at_a2;

  assign at_a1 = (addr_i == UNLOCK_A1);
  assign at_a2 = (addr_i == UNLOCK_A2);

  always_comb begin
    seq_d   = seq_q;
    view_d  = view_q;
    start_o = 1'b0;
    op_o    = OP_PROG;
    bad     = 1'b0;
    if (wr_i && !busy_i) begin
      seq_d = SQ_IDLE;
      unique case (seq_q)
        SQ_IDLE: if (at_a1 && cmd_i == CMD_UL1) seq_d = SQ_U1; else bad = 1'b1;
        SQ_U1:   if (at_a2 && cmd_i == CMD_UL2) seq_d = SQ_U2; else bad = 1'b1;
        SQ_U2: begin
          if (!at_a1) bad = 1'b1;
          else begin
            case (cmd_i)
              CMD_PROG:  seq_d  = SQ_PGM;
              CMD_ERASE: seq_d  = SQ_E3;
              CMD_ID:    view_d = VIEW_ID;
              CMD_QRY:   view_d = VIEW_QRY;
              CMD_EXIT:  view_d = VIEW_ARRAY;
              default:   bad    = 1'b1;
            endcase
          end
        end
        SQ_PGM: begin
          start_o = 1'b1;
          op_o    = OP_PROG;
        end
        SQ_E3: if (at_a1 && cmd_i == CMD_UL1) seq_d = SQ_E4; else bad = 1'b1;
        SQ_E4: if (at_a2 && cmd_i == CMD_UL2) seq_d = SQ_E5; else bad = 1'b1;
        SQ_E5: begin
          if (cmd_i == CMD_SECT) begin
            start_o = 1'b1; op_o = OP_SECT;
          end else if (cmd_i == CMD_BLK) begin
            start_o = 1'b1; op_o = OP_BLK;
          end else if (cmd_i == CMD_CHIP && at_a1) begin
            start_o = 1'b1; op_o = OP_CHIP;
          end else bad = 1'b1;
        end
        default: bad = 1'b1;
      endcase
      if (bad && view_q == VIEW_ID) view_d = VIEW_ARRAY;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= SQ_IDLE;
      view_q <= VIEW_ARRAY;
    end else begin
      seq_q  <= seq_d;
      view_q <= view_d;
    end
  end

  assign view_o = view_q;
endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic is_prog_i,
  output logic busy_o,
  output logic done_o
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PROG_LD  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] ERASE_LD = CW'(ERASE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= is_prog_i ? PROG_LD : ERASE_LD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/nor_word_array.sv
module nor_word_array
  import nor_seq_pkg::*;
#(
  parameter int LO_BITS = 2,
  parameter int SEC_LSB = 11,
  parameter int BLK_LSB = 15,
  parameter int HI_TAP  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  op_e           op_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [DW-1:0] op_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int IW = LO_BITS + 2;
  localparam int NW = 1 << IW;
  localparam logic [AW-1:0] MAP_MASK =
    (AW'(1) << HI_TAP) | (AW'(1) << SEC_LSB) | AW'((1 << LO_BITS) - 1);

  function automatic logic [AW-1:0] word_addr(logic [IW-1:0] ki);
    logic [AW-1:0] r;
    r = '0;
    for (int b = 0; b < LO_BITS; b++) r[b] = ki[b];
    r[SEC_LSB] = ki[LO_BITS];
    r[HI_TAP]  = ki[LO_BITS+1];
    return r;
  endfunction

  logic [NW-1:0][DW-1:0] words;

  for (genvar k = 0; k < NW; k++) begin : g_word
    localparam logic [AW-1:0] WA = word_addr(IW'(k));
    logic [DW-1:0] word_q;
    logic          hit_prog, hit_sect, hit_blk;

    assign hit_prog = (op_addr_i == WA);
    assign hit_sect = (op_addr_i[AW-1:SEC_LSB] == WA[AW-1:SEC_LSB]);
    assign hit_blk  = (op_addr_i[AW-1:BLK_LSB] == WA[AW-1:BLK_LSB]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= '1;
      else if (upd_i) begin
        unique case (op_i)
          OP_PROG: if (hit_prog) word_q <= word_q & op_data_i;
          OP_SECT: if (hit_sect) word_q <= '1;
          OP_BLK:  if (hit_blk)  word_q <= '1;
          OP_CHIP:               word_q <= '1;
          default: ;
        endcase
      end
    end
    assign words[k] = word_q;
  end

  logic          mapped;
  logic [IW-1:0] idx;
  assign mapped    = ((rd_addr_i & ~MAP_MASK) == '0);
  assign idx       = {rd_addr_i[HI_TAP], rd_addr_i[SEC_LSB], rd_addr_i[LO_BITS-1:0]};
  assign rd_data_o = mapped ? words[idx] : '1;
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int          PROG_CYC  = 8,
  parameter int          ERASE_CYC = 24,
  parameter int          LO_BITS   = 2,
  parameter logic [15:0] MFR_ID    = 16'h00BF,
  parameter logic [15:0] DEV_ID    = 16'h2782
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          busy_o
);
  logic wr_lvl, rd_lvl, wr_q, rd_q, wr_pulse, rd_pulse;
  assign wr_lvl   = !ce_ni && !we_ni && oe_ni;
  assign rd_lvl   = !ce_ni && !oe_ni && we_ni;
  assign wr_pulse = wr_lvl && !wr_q;
  assign rd_pulse = rd_lvl && !rd_q;

  logic          start, done;
  op_e           op_new, op_q;
  view_e         view;
  logic [AW-1:0] op_addr_q;
  logic [DW-1:0] op_data_q;
  logic          tog_q;
  logic [DW-1:0] arr_data, rd_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      op_q      <= OP_PROG;
      op_addr_q <= '0;
      op_data_q <= '0;
      tog_q     <= 1'b1;
    end else begin
      wr_q <= wr_lvl;
      rd_q <= rd_lvl;
      if (start) begin
        op_q      <= op_new;
        op_addr_q <= addr_i;
        op_data_q <= data_i;
        tog_q     <= 1'b1;
      end else if (busy_o && rd_pulse) begin
        tog_q <= ~tog_q;
      end
    end
  end

  nor_cmd_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_pulse),
    .busy_i  (busy_o),
    .addr_i  (addr_i),
    .cmd_i   (data_i[7:0]),
    .start_o (start),
    .op_o    (op_new),
    .view_o  (view)
  );

  nor_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .is_prog_i (op_new == OP_PROG),
    .busy_o    (busy_o),
    .done_o    (done)
  );

  nor_word_array #(.LO_BITS(LO_BITS)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (done),
    .op_i      (op_q),
    .op_addr_i (op_addr_q),
    .op_data_i (op_data_q),
    .rd_addr_i (addr_i),
    .rd_data_o (arr_data)
  );

  always_comb begin
    rd_val = arr_data;
    if (busy_o) begin
      rd_val    = '0;
      rd_val[7] = (op_q == OP_PROG) ? ~op_data_q[7] : 1'b0;
      rd_val[6] = tog_q;
    end else begin
      unique case (view)
        VIEW_ID: begin
          if      (addr_i == AW'(0)) rd_val = MFR_ID;
          else if (addr_i == AW'(1)) rd_val = DEV_ID;
          else                       rd_val = '0;
        end
        VIEW_QRY: begin
          if      (addr_i == AW'('h10)) rd_val = 16'h0051;
          else if (addr_i == AW'('h11)) rd_val = 16'h0052;
          else if (addr_i == AW'('h12)) rd_val = 16'h0059;
          else                          rd_val = '0;
        end
        default: rd_val = arr_data;
      endcase
    end
  end

  assign data_o = rd_lvl ? rd_val : '0;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ce_ni,
  input logic        we_ni,
  input logic        oe_ni,
  input logic [15:0] data_o,
  input logic        busy_o
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1) + 1;

  logic rd, rd_q, rd_pulse, seen_q, last_q;
  logic [CW-1:0] run_q;
  assign rd       = !ce_ni && !oe_ni && we_ni;
  assign rd_pulse = rd && !rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0; seen_q <= 1'b0; last_q <= 1'b0; run_q <= '0;
    end else begin
      rd_q <= rd;
      if (!busy_o) seen_q <= 1'b0;
      else if (rd_pulse) begin
        seen_q <= 1'b1;
        last_q <= data_o[6];
      end
      if (!busy_o) run_q <= '0;
      else if (run_q != '1) run_q <= run_q + 1'b1;
    end
  end

  a_r2_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> data_o == 16'h0000);

  a_r8_status_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd) |-> (data_o[15:8] == 8'h00 && data_o[5:0] == 6'h00));

  a_r7_busy_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(!ce_ni && !we_ni && oe_ni));

  a_r7_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < CW'(MAXC));

  a_r9_toggle_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_pulse && !seen_q) |-> data_o[6]);

  a_r9_toggle_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_pulse && seen_q) |-> data_o[6] != last_q);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ce_ni  (ce_ni),
  .we_ni  (we_ni),
  .oe_ni  (oe_ni),
  .data_o (data_o),
  .busy_o (busy_o)
);

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;
  localparam int PC = 6;
  localparam int EC = 14;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic [19:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic [15:0] data_o;
  logic        busy_o;

  int nvec = 0, nfail = 0;
  logic [15:0] mdl [16];

  always #2.5 clk = ~clk;

  nor_cmd_seq #(.PROG_CYC(PC), .ERASE_CYC(EC)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o), .busy_o(busy_o)
  );

  function automatic logic [19:0] waddr(int k);
    return (20'(k >> 3 & 1) << 16) | (20'(k >> 2 & 1) << 11) | 20'(k & 3);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [19:0] a, logic [15:0] d, int hold = 1);
    @(negedge clk);
    addr_i = a; data_i = d; oe_ni = 1'b1; ce_ni = 1'b0; we_ni = 1'b0;
    repeat (hold) @(negedge clk);
    ce_ni = 1'b1; we_ni = 1'b1;
  endtask

  task automatic bus_rd(logic [19:0] a, output logic [15:0] d);
    @(negedge clk);
    addr_i = a; we_ni = 1'b1; ce_ni = 1'b0; oe_ni = 1'b0;
    #1 d = data_o;
    @(negedge clk);
    ce_ni = 1'b1; oe_ni = 1'b1;
  endtask

  task automatic unlock3(logic [7:0] code);
    bus_wr(20'h05555, 16'h33AA);
    bus_wr(20'h02AAA, 16'hC055);
    bus_wr(20'h05555, {8'h5A, code});
  endtask

  task automatic prog(logic [19:0] a, logic [15:0] d);
    unlock3(8'hA0);
    bus_wr(a, d);
  endtask

  task automatic erase(logic [19:0] a, logic [7:0] code);
    unlock3(8'h80);
    bus_wr(20'h05555, 16'h00AA);
    bus_wr(20'h02AAA, 16'h0055);
    bus_wr(a, {8'hE1, code});
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [15:0] d;
    for (int k = 0; k < 16; k++) begin
      bus_rd(waddr(k), d);
      chk(tag, d, mdl[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [15:0] d, p;
    int n;
    for (int k = 0; k < 16; k++) mdl[k] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {15'd0, busy_o}, 16'h0000);
    chk("R1 idle bus", data_o, 16'h0000);
    check_all("R1 erased");

    // R2 unmapped and not-enabled reads
    bus_rd(20'h00004, d); chk("R2 unmapped", d, 16'hFFFF);
    bus_rd(20'h40000, d); chk("R2 unmapped hi", d, 16'hFFFF);
    @(negedge clk); oe_ni = 1'b0; ce_ni = 1'b1; addr_i = 20'h0;
    #1 chk("R2 ce high", data_o, 16'h0000);
    oe_ni = 1'b1;

    // R3 R7 R8 R9 program every mapped word, status while busy
    for (int k = 0; k < 16; k++) begin
      p = 16'(16'h1357 * (k + 1)) ^ 16'hA5C3;
      prog(waddr(k), p);
      chk("R7 busy rise", {15'd0, busy_o}, 16'h0001);
      bus_rd(20'h00000, d);
      chk("R8 R9 prog status 1", d, {8'h00, ~p[7], 1'b1, 6'h00});
      bus_rd(20'h12345, d);
      chk("R8 R9 prog status 2", d, {8'h00, ~p[7], 1'b0, 6'h00});
      wait_idle();
      mdl[k] = mdl[k] & p;
    end
    check_all("R3 program sweep");

    // R3 program ANDs with old content
    prog(waddr(5), 16'h0F0F);
    wait_idle();
    mdl[5] = mdl[5] & 16'h0F0F;
    bus_rd(waddr(5), d); chk("R3 and old", d, mdl[5]);
    chk("R8 done data", {15'd0, d[7]}, {15'd0, mdl[5][7]});

    // R7 program duration
    prog(waddr(0), 16'hFFF0);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    chk("R7 prog cycles", 16'(n), 16'(PC));
    mdl[0] = mdl[0] & 16'hFFF0;

    // R4 sector erase of sector at 800h
    erase(20'h00800, 8'h30);
    bus_rd(20'h00000, d); chk("R8 erase status", d, 16'h0040);
    n = 2;
    while (busy_o) begin n++; @(negedge clk); end
    chk("R7 erase cycles", 16'(n), 16'(EC));
    for (int k = 4; k < 8; k++) mdl[k] = 16'hFFFF;
    check_all("R4 sector erase");

    // R5 block erase of block containing 10000h
    erase(20'h10000, 8'h50);
    wait_idle();
    for (int k = 8; k < 16; k++) mdl[k] = 16'hFFFF;
    check_all("R5 block erase");

    // R11 identification view
    unlock3(8'h90);
    bus_rd(20'h00000, d); chk("R11 mfr", d, 16'h00BF);
    bus_rd(20'h00001, d); chk("R11 dev", d, 16'h2782);
    bus_rd(20'h00002, d); chk("R11 other", d, 16'h0000);

    // R10 writes while busy ignored, exit included
    prog(waddr(1), 16'h00FF);
    mdl[1] = mdl[1] & 16'h00FF;
    wait_idle();
    erase(20'h00000, 8'h30);
    unlock3(8'hF0);
    bus_wr(20'h05555, 16'h00AA);
    chk("R10 still busy", {15'd0, busy_o}, 16'h0001);
    wait_idle();
    for (int k = 0; k < 4; k++) mdl[k] = 16'hFFFF;
    bus_rd(20'h00000, d); chk("R10 exit ignored", d, 16'h00BF);
    unlock3(8'hF0);
    bus_rd(20'h00000, d); chk("R11 exit", d, mdl[0]);
    check_all("R10 erase under id");

    // R13 broken sequence discards; program not started
    bus_wr(20'h05555, 16'h00AA);
    bus_wr(20'h02AAA, 16'h0055);
    bus_wr(20'h05555, 16'h0012);
    bus_wr(waddr(3), 16'h0000);
    chk("R13 no start", {15'd0, busy_o}, 16'h0000);
    bus_rd(waddr(3), d); chk("R13 word kept", d, mdl[3]);
    unlock3(8'h90);
    bus_wr(20'h00777, 16'h0001);
    bus_rd(20'h00000, d); chk("R13 id abort", d, mdl[0]);

    // R12 query view holds across a bad write
    unlock3(8'h98);
    bus_rd(20'h00010, d); chk("R12 q", d, 16'h0051);
    bus_rd(20'h00011, d); chk("R12 r", d, 16'h0052);
    bus_rd(20'h00012, d); chk("R12 y", d, 16'h0059);
    bus_rd(20'h00013, d); chk("R12 other", d, 16'h0000);
    bus_wr(20'h00123, 16'h00FF);
    bus_rd(20'h00010, d); chk("R12 sticky", d, 16'h0051);
    unlock3(8'hF0);
    bus_rd(20'h00010, d); chk("R12 exit", d, 16'hFFFF);

    // R14 held strobe counts once
    @(negedge clk);
    addr_i = 20'h05555; data_i = 16'h00AA; ce_ni = 1'b0; we_ni = 1'b0;
    repeat (4) @(negedge clk);
    ce_ni = 1'b1; we_ni = 1'b1;
    bus_wr(20'h02AAA, 16'h0055);
    bus_wr(20'h05555, 16'h00A0);
    bus_wr(waddr(9), 16'h1234, 3);
    chk("R14 held write", {15'd0, busy_o}, 16'h0001);
    wait_idle();
    mdl[9] = mdl[9] & 16'h1234;
    bus_rd(waddr(9), d); chk("R14 programmed", d, mdl[9]);

    // R6 chip erase
    erase(20'h05555, 8'h10);
    wait_idle();
    for (int k = 0; k < 16; k++) mdl[k] = 16'hFFFF;
    check_all("R6 chip erase");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule